// File: doc/BRIEF.md
# Shared D-Channel Access Arbiter

This block decides, frame by frame, who may send on a shared upstream D-channel in a network-termination device. HDLC controllers on a time-division serial bus compete for the channel with terminals on the line interface. The arbiter watches the upstream D-bit stream and keeps a run count of consecutive ones. When the run is long enough and a bus-side controller asks for access, the arbiter gives that controller a go indication. At the same time it blocks the line-side terminals by flipping the echo bit it returns to them, so they see a collision and back off.

The run length needed is 8 or 10 ones, chosen by one control bit. A controller that has just finished a transmission must wait one extra one before it can win again, which keeps access fair. An upstream stop input halts every source. Arbitration runs only when the 12-timeslot terminal frame format is in use and the TIC bus is enabled. In any other setting the block stays idle and passes echo bits through unchanged. Requests from several bus-side sources are merged upstream of this block into one active-low request.

Top module: `dch_arbiter`

## Requirements
- R1: A synchronous reset (`rstN` low at a clock edge) clears the ones count, the fairness penalty, the grant and the echo inversion.
- R2: On each frame strobe while arbitration is enabled and no grant is held, an upstream D-bit of 1 adds one to the ones count, saturating at its maximum. A D-bit of 0 sets the count to 0.
- R3: The base threshold is 8 when `prio10` is 0 and 10 when `prio10` is 1.
- R4: On a frame strobe where the updated count reaches the threshold and `reqN` is 0, `grant` becomes 1 at that same clock edge and the count restarts from 0.
- R5: While the echo-inversion state is set, `echoOut` equals the inverse of `echoIn`. Otherwise it equals `echoIn`. The echo-inversion state is set whenever a grant is held.
- R6: A frame strobe with `stopN` at 0, while arbitration is enabled, clears the grant and the count and sets echo inversion, whatever the count was.
- R7: A frame strobe with `teFrame` or `ticEn` at 0 clears the grant, the count, the penalty and the echo inversion.
- R8: A frame strobe with `reqN` at 1 while a grant is held releases the grant and clears the count.
- R9: A release sets a penalty that raises the threshold by one (to 9 or 11). The penalty is cleared on the first strobe at which the updated count reaches the raised threshold.
- R10: `busy` is 1 when a grant is held, when echo inversion is set, or when the count is below the current threshold. Otherwise it is 0.
- R11: Register state changes only at clock edges where `frameStb` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| frameStb | input | 1 | One-cycle strobe, once per frame |
| teFrame | input | 1 | 12-timeslot terminal frame format selected |
| ticEn | input | 1 | TIC bus enabled |
| upD | input | 1 | Upstream D-bit of the current frame |
| reqN | input | 1 | Combined bus-side access request, active low |
| stopN | input | 1 | Upstream stop, 0 halts all sources |
| prio10 | input | 1 | Threshold select: 0 gives 8, 1 gives 10 |
| echoIn | input | 1 | Echo bit before arbitration |
| echoOut | output | 1 | Echo bit sent toward line terminals |
| grant | output | 1 | Stop/go indication to bus-side sources, 1 means go |
| blockLine | output | 1 | Echo inversion active |
| busy | output | 1 | Channel unavailable for a new bus-side grant |

## Verification
`grant`, `blockLine` and the count all change at the same clock edge that samples `frameStb`. So every state-derived result can be seen in the first half-cycle after that edge. `echoOut` and `busy` also depend on `echoIn` and `prio10` through logic without registers, so they follow those inputs in the same cycle. The bench changes inputs just after a rising edge. At each rising edge, a behavioural model takes its step from the same inputs the design sees. All outputs are compared at the falling edge, which keeps every check one half-cycle away from both driving and updating.

// File: rtl/dch_pkg.sv
package dch_pkg;
  typedef struct packed {
    logic clrCnt;
    logic ldCnt;
    logic setPen;
    logic clrPen;
  } dchStrobe_t;
endpackage

// File: rtl/dch_datapath.sv
module dch_datapath
  import dch_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int THR_LO = 8,
  parameter int THR_HI = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStb,
  input  logic       upD,
  input  logic       prio10,
  input  dchStrobe_t stb,
  output logic       reachNext,
  output logic       availQ
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LO_V    = THR_LO[CNT_W-1:0];
  localparam logic [CNT_W-1:0] HI_V    = THR_HI[CNT_W-1:0];

  logic [CNT_W-1:0] cntQ, cntNext;
  logic             penQ;
  logic [CNT_W-1:0] thr;

  // threshold: base chosen by prio10, plus one while the penalty stands
  assign thr = (prio10 ? HI_V : LO_V) + {{(CNT_W-1){1'b0}}, penQ};

  always_comb begin
    if (!upD)                cntNext = '0;
    else if (cntQ == CNT_MAX) cntNext = cntQ;
    else                     cntNext = cntQ + 1'b1;
  end

  assign reachNext = (cntNext >= thr);
  assign availQ    = (cntQ >= thr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      penQ <= 1'b0;
    end else if (frameStb) begin
      if (stb.clrCnt)     cntQ <= '0;
      else if (stb.ldCnt) cntQ <= cntNext;
      if (stb.setPen)     penQ <= 1'b1;
      else if (stb.clrPen) penQ <= 1'b0;
    end
  end
endmodule

// File: rtl/dch_ctrl.sv
module dch_ctrl
  import dch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStb,
  input  logic       teFrame,
  input  logic       ticEn,
  input  logic       reqN,
  input  logic       stopN,
  input  logic       reachNext,
  output dchStrobe_t stb,
  output logic       grantQ,
  output logic       blockQ
);
  logic active;
  logic grantD, blockD;

  assign active = teFrame & ticEn;

  always_comb begin
    stb    = '0;
    grantD = grantQ;
    blockD = blockQ;
    if (!active) begin
      stb.clrCnt = 1'b1;
      stb.clrPen = 1'b1;
      grantD     = 1'b0;
      blockD     = 1'b0;
    end else if (!stopN) begin
      stb.clrCnt = 1'b1;
      grantD     = 1'b0;
      blockD     = 1'b1;
    end else if (grantQ) begin
      stb.clrCnt = 1'b1;
      if (reqN) begin
        grantD     = 1'b0;
        stb.setPen = 1'b1;
      end
      blockD = grantD;
    end else begin
      stb.ldCnt = 1'b1;
      if (reachNext) begin
        stb.clrPen = 1'b1;
        if (!reqN) begin
          grantD     = 1'b1;
          stb.clrCnt = 1'b1;
        end
      end
      blockD = grantD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ <= 1'b0;
      blockQ <= 1'b0;
    end else if (frameStb) begin
      grantQ <= grantD;
      blockQ <= blockD;
    end
  end
endmodule

// File: rtl/dch_arbiter.sv
module dch_arbiter
  import dch_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int THR_LO = 8,
  parameter int THR_HI = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameStb,
  input  logic teFrame,
  input  logic ticEn,
  input  logic upD,
  input  logic reqN,
  input  logic stopN,
  input  logic prio10,
  input  logic echoIn,
  output logic echoOut,
  output logic grant,
  output logic blockLine,
  output logic busy
);
  dchStrobe_t stb;
  logic reachNext, availQ, grantQ, blockQ;

  dch_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .teFrame(teFrame),
    .ticEn(ticEn), .reqN(reqN), .stopN(stopN), .reachNext(reachNext),
    .stb(stb), .grantQ(grantQ), .blockQ(blockQ)
  );

  dch_datapath #(.CNT_W(CNT_W), .THR_LO(THR_LO), .THR_HI(THR_HI)) uDp (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .upD(upD),
    .prio10(prio10), .stb(stb), .reachNext(reachNext), .availQ(availQ)
  );

  assign grant     = grantQ;
  assign blockLine = blockQ;
  assign echoOut   = echoIn ^ blockQ;
  assign busy      = grantQ | blockQ | ~availQ;
endmodule

// File: rtl/dch_arbiter_chk.sv
module dch_arbiter_chk (
  input logic clk,
  input logic rstN,
  input logic frameStb,
  input logic teFrame,
  input logic ticEn,
  input logic reqN,
  input logic stopN,
  input logic grant,
  input logic blockLine,
  input logic busy
);
  // R7: disabled arbitration leaves nothing granted or blocked
  a_r7_idle: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && !(teFrame && ticEn)) |=> (!grant && !blockLine));

  // R6: upstream stop blocks everybody
  a_r6_stop: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && teFrame && ticEn && !stopN) |=> (!grant && blockLine));

  // R4: a grant only appears after a strobe with a request
  a_r4_grant_on_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grant) |-> ($past(frameStb) && !$past(reqN)));

  // R8: withdrawing the request releases the grant
  a_r8_release: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && grant && reqN && stopN && teFrame && ticEn) |=> !grant);

  // R10: a held grant always reads as busy
  a_r10_busy: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> busy);

  // R11: no strobe, no change
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStb && rstN) |=> ($stable(grant) && $stable(blockLine)));
endmodule

bind dch_arbiter dch_arbiter_chk uChk (
  .clk(clk), .rstN(rstN), .frameStb(frameStb), .teFrame(teFrame),
  .ticEn(ticEn), .reqN(reqN), .stopN(stopN), .grant(grant),
  .blockLine(blockLine), .busy(busy)
);

// File: tb/dch_arbiter_test.sv
module dch_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStb = 1'b0, teFrame = 1'b1, ticEn = 1'b1, upD = 1'b0;
  logic reqN = 1'b1, stopN = 1'b1, prio10 = 1'b0, echoIn = 1'b0;
  logic echoOut, grant, blockLine, busy;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string phase = "R1";

  // behavioural reference state
  int mCnt = 0, mPen = 0;
  bit mGrant = 0, mBlock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dch_arbiter uut (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .teFrame(teFrame),
    .ticEn(ticEn), .upD(upD), .reqN(reqN), .stopN(stopN), .prio10(prio10),
    .echoIn(echoIn), .echoOut(echoOut), .grant(grant),
    .blockLine(blockLine), .busy(busy)
  );

  // reference model step, same edge as the design (R2..R9, R11)
  always @(posedge clk) begin
    int thr, nc;
    if (!rstN) begin
      mCnt = 0; mPen = 0; mGrant = 0; mBlock = 0;
    end else if (frameStb) begin
      thr = (prio10 ? 10 : 8) + mPen;
      if (!(teFrame && ticEn)) begin
        mCnt = 0; mPen = 0; mGrant = 0; mBlock = 0;
      end else if (!stopN) begin
        mCnt = 0; mGrant = 0; mBlock = 1;
      end else if (mGrant) begin
        mCnt = 0;
        if (reqN) begin mGrant = 0; mPen = 1; end
        mBlock = mGrant;
      end else begin
        nc = upD ? ((mCnt < 15) ? mCnt + 1 : 15) : 0;
        if (nc >= thr) begin
          mPen = 0;
          if (!reqN) begin mGrant = 1; nc = 0; end
        end
        mCnt = nc;
        mBlock = mGrant;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) %s actual=%0d expected=%0d at %0t", req, phase, what, act, exp, $time);
    end
  endtask

  // compare every clock, half a cycle after the update edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R4", "grant", grant, mGrant);
      chk("R5", "blockLine", blockLine, mBlock);
      chk("R5", "echoOut", echoOut, echoIn ^ mBlock);
      chk("R10", "busy", busy,
          (mGrant || mBlock || (mCnt < ((prio10 ? 10 : 8) + mPen))) ? 1 : 0);
    end
  end

  task automatic sendFrame(bit d);
    @(posedge clk); #1;
    upD = d; echoIn = ~echoIn; frameStb = 1'b1;
    @(posedge clk); #1;
    frameStb = 1'b0; upD = ~d; // change without strobe: R11
  endtask

  task automatic ones(int n);
    for (int i = 0; i < n; i++) sendFrame(1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    phase = "R1";
    chk("R1", "grant after reset", grant, 0);
    chk("R1", "blockLine after reset", blockLine, 0);
    chk("R1", "busy after reset", busy, 1);
    @(posedge clk); #1; rstN = 1'b1;

    phase = "R2";
    ones(5); sendFrame(1'b0); ones(7);
    @(negedge clk); chk("R2", "busy after broken run", busy, 1);
    ones(1);
    @(negedge clk); chk("R3", "busy at 8 ones", busy, 0);

    phase = "R4";
    reqN = 1'b0; ones(1);
    @(negedge clk); chk("R4", "grant on request", grant, 1);
    sendFrame(1'b0); sendFrame(1'b1);

    phase = "R8";
    reqN = 1'b1; sendFrame(1'b1);
    @(negedge clk); chk("R8", "grant released", grant, 0);

    phase = "R9";
    reqN = 1'b0; ones(8);
    @(negedge clk); chk("R9", "no grant at 8 with penalty", grant, 0);
    ones(1);
    @(negedge clk); chk("R9", "grant at 9", grant, 1);
    reqN = 1'b1; sendFrame(1'b1);

    phase = "R3";
    prio10 = 1'b1; ones(11); reqN = 1'b0; sendFrame(1'b0);
    ones(9);
    @(negedge clk); chk("R3", "no grant at 9 with prio10", grant, 0);
    ones(1);
    @(negedge clk); chk("R3", "grant at 10", grant, 1);

    phase = "R6";
    stopN = 1'b0; sendFrame(1'b1);
    @(negedge clk); chk("R6", "stop clears grant", grant, 0);
    chk("R6", "stop blocks line", blockLine, 1);
    ones(12);
    stopN = 1'b1; reqN = 1'b1; ones(3);

    phase = "R7";
    ticEn = 1'b0; reqN = 1'b0; ones(14);
    @(negedge clk); chk("R7", "idle no grant", grant, 0);
    chk("R7", "idle echo passes", echoOut, echoIn);
    ticEn = 1'b1; teFrame = 1'b0; ones(3); teFrame = 1'b1;

    phase = "R11";
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      frameStb = ($urandom_range(0, 2) != 0);
      upD      = ($urandom_range(0, 9) != 0);
      reqN     = ($urandom_range(0, 3) == 0);
      stopN    = ($urandom_range(0, 19) != 0);
      prio10   = ($urandom_range(0, 7) == 0) ? ~prio10 : prio10;
      ticEn    = ($urandom_range(0, 49) != 0);
      echoIn   = $urandom_range(0, 1);
    end
    @(posedge clk); #1; frameStb = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule